// File: doc/BRIEF.md
# Dual-Domain Reset and Power-Up Sequencer

This block controls reset for a small controller with two supply domains. The clock/calendar domain is always on. The core/I-O domain can be switched off. An active-low master reset input reaches everything. It resets the clock/calendar domain and the core sequencer, and it clears the calendar's contents-valid flag. A supply-good input reaches only the core domain. While that input is low, the core is held in its off mode. Pull-down enables are driven onto the unpowered input buffers in that mode, so the buffers do not float. When the input returns high, the block runs a power-up sequence. It enables the PLL and waits out a start-up interval. It then waits for lock and holds the CPU in reset for a fixed number of extra cycles. After that it releases the CPU reset.

The contents-valid flag can be read through an index/data register port. Software first writes an index and then reads the data byte. The flag is set only by a software command. The master reset is the only thing that clears it. This lets firmware that boots after a supply-good cycle tell whether calendar time survived. Both asynchronous inputs pass through synchronising flop chains before they are used. Every register is clocked by the core clock, and each uses the synchronised master reset as a synchronous reset.

Top module: `dual_reset_seq`

## Requirements
- R1: After `mrst_n` is driven low, `cal_rst` reads 1 within 2 cycles. Within 3 cycles the following all hold: the contents-valid flag is 0, the stored index is 00h, `cpu_rst_n` is 0, `pll_en` is 0 and `pd_en` is 1. `cal_rst` returns to 0 2 cycles after `mrst_n` goes high.
- R2: The contents-valid flag is cleared by the master reset and by nothing else. Dropping or raising `supply_ok` leaves the flag and `cal_rst` unchanged.
- R3: A data write (`data_wr`) sets the flag to 1 when the stored index is 0Dh and `wdata[7]` is 1. A data write with `wdata[7]` equal to 0 has no effect. A data write while any other index is stored has no effect.
- R4: An index write (`idx_wr`) stores `wdata` as the index, and the index stays until the next index write. When the index is 0Dh, `rdata` is the flag in bit 7 with bits 6..0 at 0. For every other index, `rdata` is 00h.
- R5: `supply_ok` low puts the core into off mode within 3 cycles. In off mode `pd_en` is 1, `pll_en` is 0 and `cpu_rst_n` is 0. This holds from any sequence state.
- R6: Once a high `supply_ok` has passed the synchroniser, `pd_en` falls and `pll_en` rises in the same cycle. This happens 3 cycles after the input rises.
- R7: The PLL wait lasts `PLL_WAIT` cycles (default 4096). It is followed by `HOLD_CYC` cycles of reset hold (default 16). With `pll_lock` already high, `cpu_rst_n` rises exactly `3 + PLL_WAIT + HOLD_CYC` cycles after `supply_ok` rises.
- R8: If `pll_lock` is low when the wait interval expires, the sequencer waits for lock. `cpu_rst_n` then rises `HOLD_CYC + 1` cycles after `pll_lock` goes high.
- R9: `pd_en` high is never seen together with `pll_en` high or with `cpu_rst_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| supply_ok | input | 1 | Core supply good, high when powered, asynchronous |
| pll_lock | input | 1 | PLL lock indication, synchronous to clk |
| idx_wr | input | 1 | Write strobe for the register index |
| data_wr | input | 1 | Write strobe for the data byte at the stored index |
| wdata | input | 8 | Index or data being written |
| rdata | output | 8 | Data byte at the stored index |
| cal_rst | output | 1 | Clock/calendar domain reset, active high |
| cpu_rst_n | output | 1 | CPU reset, active low |
| pll_en | output | 1 | PLL enable, high from the start of the sequence |
| pd_en | output | 1 | Input pull-down enable for off mode |

## Verification
The bench cycles `supply_ok` off and on after the flag has been set, and checks that the flag still reads back as 1. A design that let the core reset reach the calendar would read 00h at that point. It times the CPU release against an early lock and against a lock that comes late. Doing so catches a counter that ignores lock and also a hold stage that is skipped or off by one. It also tries data writes with bit 7 clear, data writes under a wrong index, and an index that matches 0Dh only in its low bits. A flag decoder that is too loose would then set the flag or read it back.

// File: rtl/dual_reset_pkg.sv
package dual_reset_pkg;

    localparam int unsigned REG_W        = 8;
    localparam logic [7:0]  STATUS_IDX   = 8'h0D;
    localparam int unsigned VALID_BIT    = 7;

    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_PLL  = 2'd1,
        SEQ_HOLD = 2'd2,
        SEQ_RUN  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic             idx_wr;
        logic             data_wr;
        logic [REG_W-1:0] wdata;
    } reg_bus_t;

    typedef struct packed {
        logic cpu_rst_n;
        logic pll_en;
        logic pd_en;
    } seq_out_t;

    function automatic seq_out_t seq_decode(input seq_state_e st);
        seq_out_t o;
        o.pd_en     = (st == SEQ_OFF);
        o.pll_en    = (st != SEQ_OFF);
        o.cpu_rst_n = (st == SEQ_RUN);
        return o;
    endfunction

    function automatic logic [REG_W-1:0] status_byte(input logic flag);
        logic [REG_W-1:0] b;
        b            = '0;
        b[VALID_BIT] = flag;
        return b;
    endfunction

endpackage

// File: rtl/reset_sync_chain.sv
module reset_sync_chain #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sr[0] <= RST_VAL;
                    else     sr[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sr[g] <= RST_VAL;
                    else     sr[g] <= sr[g-1];
                end
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/cal_status_regs.sv
module cal_status_regs
    import dual_reset_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_bus_t         bus,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] idx_o,
    output logic             flag_o
);
    logic [REG_W-1:0] idx_q;
    logic             flag_q;
    logic             set_hit;

    // A set command needs the status index and a one in the valid bit.
    assign set_hit = bus.data_wr && (idx_q == STATUS_IDX) && bus.wdata[VALID_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (bus.idx_wr) idx_q <= bus.wdata;
            if (set_hit)    flag_q <= 1'b1;
        end
    end

    always_comb begin
        if (idx_q == STATUS_IDX) rdata = status_byte(flag_q);
        else                     rdata = '0;
    end

    assign idx_o  = idx_q;
    assign flag_o = flag_q;
endmodule

// File: rtl/core_power_seq.sv
module core_power_seq
    import dual_reset_pkg::*;
#(
    parameter int unsigned PLL_WAIT = 4096,
    parameter int unsigned HOLD_CYC = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sok,
    input  logic     lock,
    output seq_out_t outs
);
    localparam int unsigned MAX_CNT = (PLL_WAIT > HOLD_CYC) ? PLL_WAIT : HOLD_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CNT) + 1;
    localparam logic [CNT_W-1:0] PLL_LOAD  = CNT_W'(PLL_WAIT - 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_done;

    assign cnt_done = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SEQ_OFF: begin
                if (sok) begin
                    state_d = SEQ_PLL;
                    cnt_d   = PLL_LOAD;
                end
            end
            SEQ_PLL: begin
                if (!sok) begin
                    state_d = SEQ_OFF;
                end else if (!cnt_done) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (lock) begin
                    state_d = SEQ_HOLD;
                    cnt_d   = HOLD_LOAD;
                end
            end
            SEQ_HOLD: begin
                if (!sok) begin
                    state_d = SEQ_OFF;
                end else if (!cnt_done) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    state_d = SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                if (!sok) state_d = SEQ_OFF;
            end
            default: state_d = SEQ_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign outs = seq_decode(state_q);
endmodule

// File: rtl/dual_reset_seq.sv
module dual_reset_seq
    import dual_reset_pkg::*;
#(
    parameter int unsigned PLL_WAIT    = 4096,
    parameter int unsigned HOLD_CYC    = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       mrst_n,
    input  logic       supply_ok,
    input  logic       pll_lock,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       cal_rst,
    output logic       cpu_rst_n,
    output logic       pll_en,
    output logic       pd_en
);
    logic       mrst_n_s;
    logic       sok_s;
    reg_bus_t   bus;
    seq_out_t   seq_o;
    logic [7:0] idx_q;
    logic       vrt_flag;

    // The master reset chain has no reset of its own. It is the reset source.
    reset_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) mrst_sync_i (
        .clk (clk),
        .rst (1'b0),
        .d   (mrst_n),
        .q   (mrst_n_s)
    );

    assign cal_rst = !mrst_n_s;

    reset_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) sok_sync_i (
        .clk (clk),
        .rst (cal_rst),
        .d   (supply_ok),
        .q   (sok_s)
    );

    assign bus.idx_wr  = idx_wr;
    assign bus.data_wr = data_wr;
    assign bus.wdata   = wdata;

    // The calendar status is reset only by the master reset.
    cal_status_regs regs_i (
        .clk    (clk),
        .rst    (cal_rst),
        .bus    (bus),
        .rdata  (rdata),
        .idx_o  (idx_q),
        .flag_o (vrt_flag)
    );

    core_power_seq #(.PLL_WAIT(PLL_WAIT), .HOLD_CYC(HOLD_CYC)) seq_i (
        .clk  (clk),
        .rst  (cal_rst),
        .sok  (sok_s),
        .lock (pll_lock),
        .outs (seq_o)
    );

    assign cpu_rst_n = seq_o.cpu_rst_n;
    assign pll_en    = seq_o.pll_en;
    assign pd_en     = seq_o.pd_en;
endmodule

// File: rtl/dual_reset_seq_chk.sv
module dual_reset_seq_chk #(
    parameter int unsigned PLL_WAIT = 4096,
    parameter int unsigned HOLD_CYC = 16
) (
    input logic       clk,
    input logic       cal_rst,
    input logic       vrt_flag,
    input logic [7:0] idx_q,
    input logic       data_wr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       cpu_rst_n,
    input logic       pll_en,
    input logic       pd_en
);
    logic        armed = 1'b0;
    logic [31:0] seq_cnt = '0;

    always_ff @(posedge clk) begin
        if (cal_rst) armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!pll_en || cpu_rst_n) seq_cnt <= '0;
        else if (seq_cnt != 32'hFFFF_FFFF) seq_cnt <= seq_cnt + 1;
    end

    // R2
    flag_clear_src_chk: assert property (@(posedge clk) disable iff (!armed)
        $fell(vrt_flag) |-> $past(cal_rst));

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!armed || cal_rst)
        (data_wr && wdata[7] && idx_q == 8'h0D) |=> vrt_flag);

    // R4
    other_idx_zero_chk: assert property (@(posedge clk) disable iff (!armed)
        (idx_q != 8'h0D) |-> (rdata == 8'h00));

    // R6
    pd_pll_swap_chk: assert property (@(posedge clk) disable iff (!armed || cal_rst)
        $fell(pd_en) |-> $rose(pll_en));

    // R7
    release_wait_chk: assert property (@(posedge clk) disable iff (!armed || cal_rst)
        $rose(cpu_rst_n) |-> (seq_cnt >= PLL_WAIT + HOLD_CYC));

    // R9
    off_mode_excl_chk: assert property (@(posedge clk) disable iff (!armed)
        pd_en |-> (!cpu_rst_n && !pll_en));
endmodule

bind dual_reset_seq dual_reset_seq_chk #(.PLL_WAIT(PLL_WAIT), .HOLD_CYC(HOLD_CYC)) chk_i (
    .clk       (clk),
    .cal_rst   (cal_rst),
    .vrt_flag  (vrt_flag),
    .idx_q     (idx_q),
    .data_wr   (data_wr),
    .wdata     (wdata),
    .rdata     (rdata),
    .cpu_rst_n (cpu_rst_n),
    .pll_en    (pll_en),
    .pd_en     (pd_en)
);

// File: tb/dual_reset_seq_tb_top.sv
`timescale 1ns/1ps
module dual_reset_seq_tb_top;
    localparam int PLL_WAIT = 4096;
    localparam int HOLD_CYC = 16;
    localparam int SYNC_LAT = 3;

    logic       clk = 1'b0;
    logic       mrst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       pll_lock = 1'b0;
    logic       idx_wr = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       cal_rst, cpu_rst_n, pll_en, pd_en;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dual_reset_seq #(.PLL_WAIT(PLL_WAIT), .HOLD_CYC(HOLD_CYC)) dut_i (
        .clk(clk), .mrst_n(mrst_n), .supply_ok(supply_ok), .pll_lock(pll_lock),
        .idx_wr(idx_wr), .data_wr(data_wr), .wdata(wdata), .rdata(rdata),
        .cal_rst(cal_rst), .cpu_rst_n(cpu_rst_n), .pll_en(pll_en), .pd_en(pd_en)
    );

    // op: 0 index write, 1 data write, 2 read only
    typedef struct packed {
        logic [1:0] op;
        logic [7:0] d;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h0D, 8'h00},  // R1 flag cleared after master reset
        '{2'd1, 8'h00, 8'h00},  // R3 bit 7 clear
        '{2'd1, 8'h7F, 8'h00},  // R3 bit 7 clear, others set
        '{2'd0, 8'h0C, 8'h00},  // R4 other index
        '{2'd1, 8'h80, 8'h00},  // R3 write under wrong index
        '{2'd0, 8'h0D, 8'h00},  // R3 flag still clear
        '{2'd1, 8'hFF, 8'h80},  // R3 set command
        '{2'd1, 8'h00, 8'h80},  // R3 zero write keeps flag
        '{2'd0, 8'h8D, 8'h00},  // R4 upper bit differs
        '{2'd0, 8'h0D, 8'h80}   // R4 index back at status
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig_sel(input int sel);
        case (sel)
            0: return cal_rst;
            1: return cpu_rst_n;
            2: return pll_en;
            default: return pd_en;
        endcase
    endfunction

    // Counts negedges after the current one until the signal reaches val.
    task automatic count_until(input int sel, input logic val, input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sig_sel(sel) !== val && n < limit);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    endtask

    initial begin
        int n;
        // Reset state, R1
        repeat (6) @(negedge clk);
        check("R1 cal_rst in reset", cal_rst, 1);
        check("R1 rdata in reset", rdata, 0);
        check("R1 cpu_rst_n in reset", cpu_rst_n, 0);
        check("R1 pd_en in reset", pd_en, 1);
        check("R1 pll_en in reset", pll_en, 0);

        mrst_n = 1'b1;
        count_until(0, 1'b0, 20, n);
        check("R1 cal_rst release latency", n, 2);
        repeat (3) @(negedge clk);
        check("R5 off with supply low", pd_en, 1);

        // Register vector table
        for (int i = 0; i < NV; i++) begin
            idx_wr  = (VECS[i].op == 2'd0);
            data_wr = (VECS[i].op == 2'd1);
            wdata   = VECS[i].d;
            @(negedge clk);
            idx_wr  = 1'b0;
            data_wr = 1'b0;
            check($sformatf("R3/R4 vector %0d rdata", i), rdata, VECS[i].exp);
        end

        // Power-up with lock already present, R6 R7
        pll_lock  = 1'b1;
        supply_ok = 1'b1;
        count_until(3, 1'b0, 50, n);
        check("R6 pd_en fall latency", n, SYNC_LAT);
        check("R6 pll_en with pd_en fall", pll_en, 1);
        begin
            int m;
            count_until(1, 1'b1, 6000, m);
            check("R7 cpu release latency", n + m, SYNC_LAT + PLL_WAIT + HOLD_CYC);
        end
        check("R2 flag kept through power-up", rdata, 8'h80);

        // Supply loss from run, R5 R2
        supply_ok = 1'b0;
        count_until(3, 1'b1, 50, n);
        check("R5 off-mode entry latency", n, SYNC_LAT);
        check("R5 cpu_rst_n in off mode", cpu_rst_n, 0);
        check("R5 pll_en in off mode", pll_en, 0);
        check("R2 flag kept after supply loss", rdata, 8'h80);
        check("R2 cal_rst untouched by supply loss", cal_rst, 0);

        // Late lock, R8
        pll_lock  = 1'b0;
        supply_ok = 1'b1;
        repeat (PLL_WAIT + 100) @(negedge clk);
        check("R8 held without lock", cpu_rst_n, 0);
        check("R8 pll_en during wait", pll_en, 1);
        pll_lock = 1'b1;
        count_until(1, 1'b1, 100, n);
        check("R8 release after late lock", n, HOLD_CYC + 1);

        // Master reset while running, R1
        mrst_n = 1'b0;
        count_until(0, 1'b1, 20, n);
        check("R1 cal_rst assert latency", n, 2);
        @(negedge clk);
        check("R1 cpu_rst_n after master reset", cpu_rst_n, 0);
        check("R1 pd_en after master reset", pd_en, 1);
        check("R1 index cleared", rdata, 0);
        mrst_n = 1'b1;
        repeat (4) @(negedge clk);
        idx_wr = 1'b1;
        wdata  = 8'h0D;
        @(negedge clk);
        idx_wr = 1'b0;
        check("R1 flag cleared by master reset", rdata, 8'h00);
        count_until(1, 1'b1, 6000, n);
        check("R7 sequence resumes after master reset", cpu_rst_n, 1);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule